// File: doc/BRIEF.md
# Accumulator Logic and Compare ALU with Status Flags

This block is the byte-wide logic and compare unit of a small accumulator machine. Each transfer brings in an operation code, the accumulator value, one operand byte and the current four status flags: zero (Z), subtract (N), half-carry (H) and carry (C). The operand byte has already been fetched by the surrounding datapath, and may come from any general register, from an immediate byte or from memory. The block returns the result byte, a write enable, a destination select (accumulator or the operand's own location), the new flags, and the flags packed into a byte.

The unit performs AND, OR, XOR, compare, increment and decrement. Each operation has its own flag rule. AND forces H high, while OR and XOR clear it. Compare only updates flags and never writes. Increment and decrement act on the operand byte and keep the incoming carry. Addition with carry, shifts and rotates are not part of this block.

Both edges of the block are valid/ready streams with one register stage between them. An input is accepted on a clock edge where `in_valid` and `in_ready` are both high, and its result appears on the next cycle. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds steady and no new input is taken. There is no buffering beyond that single stage.

Top module: `acc_logic_alu`

## Requirements
- R1: Op code 0 (AND) returns acc AND operand with out_we=1 and out_to_acc=1. Flags: Z=(result==0), N=0, H=1, C=0.
- R2: Op codes 1 (OR) and 2 (XOR) return the bitwise result with out_we=1 and out_to_acc=1. Flags: Z=(result==0), N=0, H=0, C=0.
- R3: Op code 3 (compare) has out_we=0 and out_result equal to the accumulator. Flags: N=1, Z=(acc==operand), C=(acc<operand unsigned), H=(low nibble of acc < low nibble of operand).
- R4: Op code 4 (increment) returns operand+1, wrapping modulo 256, with out_we=1 and out_to_acc=0. Flags: N=0, Z on a zero 8-bit result, H=1 when the operand's low nibble is 0xF, C equal to the incoming C.
- R5: Op code 5 (decrement) returns operand-1, wrapping modulo 256, with out_we=1 and out_to_acc=0. Flags: N=1, Z on a zero 8-bit result, H=1 when the operand's low nibble is 0x0, C equal to the incoming C.
- R6: Op codes 6 and 7 are inert. They give out_we=0, out_result equal to the accumulator, and flags equal to the incoming flags.
- R7: out_flag_byte holds Z in bit 7, N in bit 6, H in bit 5 and C in bit 4, and bits 3..0 are zero. out_flags is ordered {Z,N,H,C} from bit 3 down to bit 0.
- R8: A transfer accepted on one edge appears on out_valid after that edge. in_ready = !out_valid || out_ready. While out_valid=1 and out_ready=0, all outputs hold and inputs are ignored.
- R9: During and after reset, out_valid=0, out_we=0, out_flags=0, out_flag_byte=0 and in_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Input transfer can be taken |
| in_op | input | 3 | Operation code |
| in_acc | input | 8 | Accumulator value |
| in_opnd | input | 8 | Operand byte |
| in_flags | input | 4 | Current flags {Z,N,H,C} |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 8 | Result byte |
| out_we | output | 1 | Destination write enable |
| out_to_acc | output | 1 | 1: destination is accumulator, 0: operand location |
| out_flags | output | 4 | New flags {Z,N,H,C} |
| out_flag_byte | output | 8 | Flags packed into a byte |

## Verification
The bench targets the nibble boundaries. It increments 0x0F and 0xFF, decrements 0x00 and 0x10, and compares values whose low nibble borrows while the full byte does not. A design that takes H from the wrong bit, or that lets Z look at a ninth bit, fails on these cases. Increment and decrement run with the incoming carry both set and clear, so a design that drives C from the arithmetic result is caught. Compare is checked for equal, greater and smaller operands, which exposes a design that writes the accumulator or inverts the borrow. The inert op codes, and a stalled output presented with a different input, show whether stray values leak into the flags or into a held result.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_XOR  = 3'd2,
    OP_CMP  = 3'd3,
    OP_INC  = 3'd4,
    OP_DEC  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   res,
  output logic            zero
);
  always_comb begin
    unique case (op)
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = a & b;
    endcase
    zero = (res == '0);
  end
endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [DW-1:0]   res,
  output logic            half,
  output logic            borrow,
  output logic            zero
);
  localparam int NIB = DW / 2;

  logic [DW:0] diff_w;

  always_comb begin
    diff_w = {1'b0, a} - {1'b0, b};
    borrow = diff_w[DW];
    unique case (op)
      OP_INC: begin
        res  = b + 1'b1;
        half = &b[NIB-1:0];
      end
      OP_DEC: begin
        res  = b - 1'b1;
        half = ~|b[NIB-1:0];
      end
      default: begin
        res  = diff_w[DW-1:0];
        half = (a[NIB-1:0] < b[NIB-1:0]);
      end
    endcase
    zero = (res == '0);
  end
endmodule

// File: rtl/acc_alu_flagpack.sv
module acc_alu_flagpack
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_flags_t    flags,
  output logic [DW-1:0] packed_byte
);
  localparam int PAD = DW - 4;

  generate
    if (PAD > 0) begin : g_pad
      assign packed_byte = {flags, {PAD{1'b0}}};
    end else begin : g_nopad
      assign packed_byte = flags;
    end
  endgenerate
endmodule

// File: rtl/acc_logic_alu.sv
module acc_logic_alu
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_op,
  input  logic [DW-1:0] in_acc,
  input  logic [DW-1:0] in_opnd,
  input  logic [3:0]    in_flags,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_result,
  output logic          out_we,
  output logic          out_to_acc,
  output logic [3:0]    out_flags,
  output logic [DW-1:0] out_flag_byte
);
  alu_op_e    op;
  alu_flags_t fin;
  logic [DW-1:0] lg_res, ar_res;
  logic lg_zero, ar_zero, ar_half, ar_borrow;

  logic [DW-1:0] nx_res;
  logic          nx_we, nx_to_acc;
  alu_flags_t    nx_flags;

  logic [DW-1:0] r_res;
  logic          r_valid, r_we, r_to_acc;
  alu_flags_t    r_flags;

  assign op  = alu_op_e'(in_op);
  assign fin = alu_flags_t'(in_flags);

  acc_alu_logic #(.DW(DW)) u_logic (
    .op(op), .a(in_acc), .b(in_opnd), .res(lg_res), .zero(lg_zero)
  );

  acc_alu_arith #(.DW(DW)) u_arith (
    .op(op), .a(in_acc), .b(in_opnd), .res(ar_res),
    .half(ar_half), .borrow(ar_borrow), .zero(ar_zero)
  );

  always_comb begin
    nx_res    = in_acc;
    nx_we     = 1'b0;
    nx_to_acc = 1'b1;
    nx_flags  = fin;
    unique case (op)
      OP_AND: begin
        nx_res   = lg_res;
        nx_we    = 1'b1;
        nx_flags = '{z: lg_zero, n: 1'b0, h: 1'b1, c: 1'b0};
      end
      OP_OR, OP_XOR: begin
        nx_res   = lg_res;
        nx_we    = 1'b1;
        nx_flags = '{z: lg_zero, n: 1'b0, h: 1'b0, c: 1'b0};
      end
      OP_CMP: begin
        nx_flags = '{z: ar_zero, n: 1'b1, h: ar_half, c: ar_borrow};
      end
      OP_INC: begin
        nx_res    = ar_res;
        nx_we     = 1'b1;
        nx_to_acc = 1'b0;
        nx_flags  = '{z: ar_zero, n: 1'b0, h: ar_half, c: fin.c};
      end
      OP_DEC: begin
        nx_res    = ar_res;
        nx_we     = 1'b1;
        nx_to_acc = 1'b0;
        nx_flags  = '{z: ar_zero, n: 1'b1, h: ar_half, c: fin.c};
      end
      default: ;
    endcase
  end

  assign in_ready = !r_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_valid  <= 1'b0;
      r_res    <= '0;
      r_we     <= 1'b0;
      r_to_acc <= 1'b0;
      r_flags  <= '0;
    end else if (in_ready) begin
      r_valid <= in_valid;
      if (in_valid) begin
        r_res    <= nx_res;
        r_we     <= nx_we;
        r_to_acc <= nx_to_acc;
        r_flags  <= nx_flags;
      end
    end
  end

  acc_alu_flagpack #(.DW(DW)) u_pack (
    .flags(r_flags), .packed_byte(out_flag_byte)
  );

  assign out_valid  = r_valid;
  assign out_result = r_res;
  assign out_we     = r_valid & r_we;
  assign out_to_acc = r_to_acc;
  assign out_flags  = r_flags;
endmodule

// File: rtl/acc_logic_alu_chk.sv
module acc_logic_alu_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [2:0]    in_op,
  input logic [DW-1:0] in_acc,
  input logic [DW-1:0] in_opnd,
  input logic [3:0]    in_flags,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_result,
  input logic          out_we,
  input logic [3:0]    out_flags,
  input logic [DW-1:0] out_flag_byte
);
  logic take;
  assign take = in_valid && in_ready;

  a_r1_and_policy: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == 3'd0 |=> out_flags[2:0] == 3'b010
      && out_result == ($past(in_acc) & $past(in_opnd)) && out_we);

  a_r3_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == 3'd3 |=> !out_we && out_flags[2]
      && out_result == $past(in_acc));

  a_r4_inc_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == 3'd4 |=> out_flags[0] == $past(in_flags[0]) && !out_flags[2]);

  a_r5_dec_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == 3'd5 |=> out_flags[0] == $past(in_flags[0]) && out_flags[2]);

  a_r6_inert_flags: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op[2:1] == 2'b11 |=> !out_we && out_flags == $past(in_flags));

  a_r7_flag_byte: assert property (@(posedge clk) disable iff (!rst_n)
    out_flag_byte == {out_flags, {(DW-4){1'b0}}});

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
      && $stable(out_flags) && $stable(out_we));

  a_r8_stall_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

bind acc_logic_alu acc_logic_alu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_acc(in_acc), .in_opnd(in_opnd), .in_flags(in_flags),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_we(out_we), .out_flags(out_flags), .out_flag_byte(out_flag_byte)
);

// File: tb/acc_logic_alu_bench.sv
module acc_logic_alu_bench;
  localparam int CLK_P = 10;
  localparam int NV = 17;
  // {op[36:34], acc[33:26], opnd[25:18], fin[17:14], res[13:6], we[5], to_acc[4], flags[3:0]}
  localparam logic [36:0] VEC [NV] = '{
    {3'd0, 8'hF0, 8'h0F, 4'h0, 8'h00, 1'b1, 1'b1, 4'b1010},
    {3'd0, 8'h3C, 8'h2A, 4'hF, 8'h28, 1'b1, 1'b1, 4'b0010},
    {3'd1, 8'h00, 8'h00, 4'hF, 8'h00, 1'b1, 1'b1, 4'b1000},
    {3'd1, 8'h50, 8'h05, 4'h0, 8'h55, 1'b1, 1'b1, 4'b0000},
    {3'd2, 8'hA5, 8'hA5, 4'h0, 8'h00, 1'b1, 1'b1, 4'b1000},
    {3'd2, 8'h0F, 8'hFF, 4'h7, 8'hF0, 1'b1, 1'b1, 4'b0000},
    {3'd3, 8'h42, 8'h42, 4'h0, 8'h42, 1'b0, 1'b1, 4'b1100},
    {3'd3, 8'h10, 8'h01, 4'h0, 8'h10, 1'b0, 1'b1, 4'b0110},
    {3'd3, 8'h05, 8'h20, 4'h0, 8'h05, 1'b0, 1'b1, 4'b0101},
    {3'd4, 8'h99, 8'hFF, 4'h1, 8'h00, 1'b1, 1'b0, 4'b1011},
    {3'd4, 8'h99, 8'h0F, 4'h0, 8'h10, 1'b1, 1'b0, 4'b0010},
    {3'd4, 8'h99, 8'h41, 4'h1, 8'h42, 1'b1, 1'b0, 4'b0001},
    {3'd5, 8'h99, 8'h01, 4'h0, 8'h00, 1'b1, 1'b0, 4'b1100},
    {3'd5, 8'h99, 8'h00, 4'h1, 8'hFF, 1'b1, 1'b0, 4'b0111},
    {3'd5, 8'h99, 8'h10, 4'h0, 8'h0F, 1'b1, 1'b0, 4'b0110},
    {3'd6, 8'h77, 8'h11, 4'hA, 8'h77, 1'b0, 1'b1, 4'b1010},
    {3'd7, 8'h33, 8'h11, 4'h5, 8'h33, 1'b0, 1'b1, 4'b0101}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_op = '0;
  logic [7:0] in_acc = '0;
  logic [7:0] in_opnd = '0;
  logic [3:0] in_flags = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [7:0] out_result;
  logic out_we, out_to_acc;
  logic [3:0] out_flags;
  logic [7:0] out_flag_byte;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  acc_logic_alu u_acc_logic_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_acc(in_acc), .in_opnd(in_opnd), .in_flags(in_flags),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_we(out_we), .out_to_acc(out_to_acc), .out_flags(out_flags),
    .out_flag_byte(out_flag_byte)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1 and";
      3'd1, 3'd2: return "R2 or/xor";
      3'd3: return "R3 compare";
      3'd4: return "R4 increment";
      3'd5: return "R5 decrement";
      default: return "R6 inert op";
    endcase
  endfunction

  initial begin
    #(CLK_P * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R9 flag byte", {24'd0, out_flag_byte}, 32'd0);
    chk("R9 in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [36:0] v;
      v = VEC[i];
      @(negedge clk);
      in_op = v[36:34]; in_acc = v[33:26]; in_opnd = v[25:18]; in_flags = v[17:14];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk({tag_of(v[36:34]), " valid R8"}, {31'd0, out_valid}, 32'd1);
      chk({tag_of(v[36:34]), " result"}, {24'd0, out_result}, {24'd0, v[13:6]});
      chk({tag_of(v[36:34]), " we"}, {31'd0, out_we}, {31'd0, v[5]});
      if (v[5]) chk({tag_of(v[36:34]), " dest"}, {31'd0, out_to_acc}, {31'd0, v[4]});
      chk({tag_of(v[36:34]), " flags"}, {28'd0, out_flags}, {28'd0, v[3:0]});
      chk("R7 packed flags", {24'd0, out_flag_byte}, {24'd0, v[3:0], 4'b0000});
    end

    // R8: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 3'd0; in_acc = 8'h3C; in_opnd = 8'h2A; in_flags = 4'h0; in_valid = 1'b1;
    @(negedge clk);
    chk("R8 stalled in_ready", {31'd0, in_ready}, 32'd0);
    in_op = 3'd1; in_acc = 8'hFF; in_opnd = 8'hFF; in_flags = 4'hF;
    repeat (2) @(negedge clk);
    chk("R8 held valid", {31'd0, out_valid}, 32'd1);
    chk("R8 held result", {24'd0, out_result}, 32'h28);
    chk("R8 held flags", {28'd0, out_flags}, 32'b0010);
    out_ready = 1'b1;
    in_acc = 8'hFF; in_opnd = 8'h00;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 next result", {24'd0, out_result}, 32'hFF);
    chk("R8 next valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    chk("R8 drained", {31'd0, out_valid}, 32'd0);
    chk("R8 drained we", {31'd0, out_we}, 32'd0);

    // R9: reset again clears a pending result
    in_op = 3'd4; in_opnd = 8'h20; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 reset clears valid", {31'd0, out_valid}, 32'd0);
    chk("R9 reset clears flags", {28'd0, out_flags}, 32'd0);
    rst_n = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule